// File: doc/BRIEF.md
# UART Line Status and Interrupt Logic

This block keeps the line status byte, the interrupt enable byte and the single interrupt request line of a UART that has 16-entry receive and transmit FIFOs. It does not hold any data. It reads status levels and event pulses from the receive FIFO, the transmit path and the modem and flow-control logic next to it. It turns them into readable status bits and into one level-sensitive interrupt.

A host reaches the two bytes through a plain register port. One select bit picks either the status byte or the enable byte. A read strobe returns the byte one cycle later, and that read also acknowledges the latched status events. A write strobe updates the enable byte. Three of the enable bits (sleep, received-Xoff, RTS rising edge) accept writes only while the enhanced-features input is high. There is no streaming data path, so the port has no valid/ready handshake: each strobe lasts one cycle and is always accepted.

Top module: `uart_lsr_irq`

## Requirements
- R1: Status bit 0 equals the receive-not-empty input.
- R2: An overrun pulse sets status bit 1 from the next cycle. It stays set until a status read. If a new pulse arrives in the same cycle as a clearing read, the bit stays set.
- R3: While the receive FIFO is not empty, status bits 2, 3 and 4 show the head character's error input, in the order bit 0 = parity, bit 1 = framing, bit 2 = break. While the FIFO is empty these status bits are 0.
- R4: Status bit 5 equals transmit-FIFO-empty. Status bit 6 is 1 only when the transmit FIFO and the shift register are both empty.
- R5: Status bit 7 becomes 1 the cycle after the error-present input is high. A status read clears it, unless error-present is still high in that cycle.
- R6: With enable bit 0 set, the receive-data interrupt is pending when the FIFO is not empty (FIFO-enable = 0) or when the trigger level is reached (FIFO-enable = 1).
- R7: Enable bit 1 gates a pending interrupt while the transmit FIFO is empty. Enable bit 2 gates one while any of status bits 1 to 4 is set. Enable bit 3 gates the modem-status change input.
- R8: All enable bits reset to 0. Bits 0 to 3 are always writable. Bits 4 to 6 change only while enhanced-features = 1. Bit 7 always reads 0.
- R9: A low-to-high transition of the RTS pin, and a received-Xoff pulse, each set a latched event. The event is gated by enable bit 6 or enable bit 5 respectively, and a status read clears it.
- R10: The interrupt output is the OR of all enabled pending sources. With enable bits 0 to 3, 5 and 6 all 0, it stays low whatever the inputs, so the host can poll the status byte.
- R11: A read strobe with select 0 returns the status byte, and with select 1 the enable byte, on the read-data output in the next cycle. The read data holds until the next read. Writes with select 0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | 0 = status byte, 1 = enable byte |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered |
| fifo_en | input | 1 | FIFO mode enabled |
| efr_en | input | 1 | Enhanced-features enable |
| rx_nonempty | input | 1 | Receive FIFO/holding register has data |
| rx_trig_hit | input | 1 | Receive FIFO at trigger level |
| head_err | input | 3 | Head character errors: break, framing, parity |
| rx_err_present | input | 1 | Some stored character carries an error |
| tx_fifo_empty | input | 1 | Transmit FIFO empty |
| tsr_empty | input | 1 | Transmit shift register empty |
| ovr_evt | input | 1 | Overrun pulse |
| msr_pend | input | 1 | Modem status change pending (level) |
| xoff_evt | input | 1 | Received-Xoff pulse |
| rts_pin | input | 1 | RTS pin level |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets a clearing read that lands while the error-present level is still high. A design that lets the clear win would drop status bit 7 even though bad characters remain. It writes all ones to the enable byte with enhanced features off and then on. A design with wrong gating would unlock the sleep, Xoff and RTS bits too early, or fail to keep them when enhanced features are turned off. It checks that RTS raises the interrupt once per rising edge and never on a falling edge or a held-high level. It also checks that error bits read as 0 while the receive FIFO is empty. With every enable cleared, it drives all sources active at once: any leak into the interrupt line would break polled mode.

// File: rtl/uart_lsr_pkg.sv
package uart_lsr_pkg;
  localparam int REG_W = 8;
  localparam int ERR_W = 3;
  localparam int EN_W  = 7;

  // status bit positions (decoded by host software)
  localparam int ST_RXRDY  = 0;
  localparam int ST_OVR    = 1;
  localparam int ST_PAR    = 2;
  localparam int ST_BRK    = 4;
  localparam int ST_TXFE   = 5;
  localparam int ST_TXIDLE = 6;
  localparam int ST_ANYERR = 7;

  // enable bit positions
  localparam int EN_RXD   = 0;
  localparam int EN_TXR   = 1;
  localparam int EN_LINE  = 2;
  localparam int EN_MDM   = 3;
  localparam int EN_SLEEP = 4;
  localparam int EN_XOFF  = 5;
  localparam int EN_RTS   = 6;
  localparam int EN_BASE_W = 4;

  // sticky event slots
  localparam int SK_OVR  = 0;
  localparam int SK_ERR  = 1;
  localparam int SK_XOFF = 2;
  localparam int SK_RTS  = 3;
  localparam int SK_N    = 4;

  typedef enum logic {SEL_STATUS = 1'b0, SEL_ENABLE = 1'b1} reg_sel_e;
endpackage

// File: rtl/sticky_flag.sv
module sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)     q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;   // a new event beats the acknowledge
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/rise_detect.sv
module rise_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o
);
  logic prev_q;
  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= pin_i;   // reset captures the present level
    else        prev_q <= pin_i;
  end
  assign rise_o = pin_i & ~prev_q;
endmodule

// File: rtl/status_track.sv
module status_track
  import uart_lsr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_nonempty,
  input  logic [ERR_W-1:0] head_err,
  input  logic             rx_err_present,
  input  logic             tx_fifo_empty,
  input  logic             tsr_empty,
  input  logic             ovr_evt,
  input  logic             xoff_evt,
  input  logic             rts_pin,
  input  logic             status_rd,
  output logic [REG_W-1:0] status,
  output logic             xoff_pend,
  output logic             rts_pend
);
  logic             rts_rise;
  logic [SK_N-1:0]  sk_set;
  logic [SK_N-1:0]  sk_q;

  rise_detect u_rts_edge (
    .clk(clk), .rst_n(rst_n), .pin_i(rts_pin), .rise_o(rts_rise)
  );

  always_comb begin
    sk_set          = '0;
    sk_set[SK_OVR]  = ovr_evt;
    sk_set[SK_ERR]  = rx_err_present;
    sk_set[SK_XOFF] = xoff_evt;
    sk_set[SK_RTS]  = rts_rise;
  end

  for (genvar g = 0; g < SK_N; g++) begin : g_sticky
    sticky_flag u_flag (
      .clk(clk), .rst_n(rst_n), .set_i(sk_set[g]), .clr_i(status_rd), .q_o(sk_q[g])
    );
  end

  always_comb begin
    status                      = '0;
    status[ST_RXRDY]            = rx_nonempty;
    status[ST_OVR]              = sk_q[SK_OVR];
    status[ST_BRK:ST_PAR]       = rx_nonempty ? head_err : '0;
    status[ST_TXFE]             = tx_fifo_empty;
    status[ST_TXIDLE]           = tx_fifo_empty & tsr_empty;
    status[ST_ANYERR]           = sk_q[SK_ERR];
  end

  assign xoff_pend = sk_q[SK_XOFF];
  assign rts_pend  = sk_q[SK_RTS];
endmodule

// File: rtl/enable_reg.sv
module enable_reg
  import uart_lsr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic            efr_en,
  input  logic [EN_W-1:0] wdata,
  output logic [EN_W-1:0] en
);
  for (genvar b = 0; b < EN_W; b++) begin : g_bit
    logic allow;
    if (b < EN_BASE_W) begin : g_base
      assign allow = wr;
    end else begin : g_ext
      assign allow = wr & efr_en;
    end
    always_ff @(posedge clk) begin
      if (!rst_n)     en[b] <= 1'b0;
      else if (allow) en[b] <= wdata[b];
    end
  end
endmodule

// File: rtl/irq_merge.sv
module irq_merge
  import uart_lsr_pkg::*;
(
  input  logic            [EN_W-1:0] en,
  input  logic                       fifo_en,
  input  logic                       rx_nonempty,
  input  logic                       rx_trig_hit,
  input  logic                       tx_fifo_empty,
  input  logic [ST_BRK:ST_OVR]       line_bits,
  input  logic                       msr_pend,
  input  logic                       xoff_pend,
  input  logic                       rts_pend,
  output logic                       irq
);
  logic rxd_src;
  assign rxd_src = fifo_en ? rx_trig_hit : rx_nonempty;

  assign irq = (en[EN_RXD]  & rxd_src)
             | (en[EN_TXR]  & tx_fifo_empty)
             | (en[EN_LINE] & (|line_bits))
             | (en[EN_MDM]  & msr_pend)
             | (en[EN_XOFF] & xoff_pend)
             | (en[EN_RTS]  & rts_pend);
endmodule

// File: rtl/uart_lsr_irq.sv
module uart_lsr_irq
  import uart_lsr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_sel,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  input  logic             fifo_en,
  input  logic             efr_en,
  input  logic             rx_nonempty,
  input  logic             rx_trig_hit,
  input  logic [ERR_W-1:0] head_err,
  input  logic             rx_err_present,
  input  logic             tx_fifo_empty,
  input  logic             tsr_empty,
  input  logic             ovr_evt,
  input  logic             msr_pend,
  input  logic             xoff_evt,
  input  logic             rts_pin,
  output logic             irq
);
  logic [REG_W-1:0] status_w;
  logic [EN_W-1:0]  en_w;
  logic             xoff_pend, rts_pend;
  logic             status_rd, enable_wr;
  logic             unused_wtop;

  assign status_rd   = rd_en & (reg_sel == SEL_STATUS);
  assign enable_wr   = wr_en & (reg_sel == SEL_ENABLE);
  assign unused_wtop = wdata[REG_W-1];

  status_track u_status (
    .clk(clk), .rst_n(rst_n),
    .rx_nonempty(rx_nonempty), .head_err(head_err), .rx_err_present(rx_err_present),
    .tx_fifo_empty(tx_fifo_empty), .tsr_empty(tsr_empty),
    .ovr_evt(ovr_evt), .xoff_evt(xoff_evt), .rts_pin(rts_pin),
    .status_rd(status_rd), .status(status_w),
    .xoff_pend(xoff_pend), .rts_pend(rts_pend)
  );

  enable_reg u_enable (
    .clk(clk), .rst_n(rst_n), .wr(enable_wr), .efr_en(efr_en),
    .wdata(wdata[EN_W-1:0]), .en(en_w)
  );

  irq_merge u_irq (
    .en(en_w), .fifo_en(fifo_en), .rx_nonempty(rx_nonempty), .rx_trig_hit(rx_trig_hit),
    .tx_fifo_empty(tx_fifo_empty), .line_bits(status_w[ST_BRK:ST_OVR]),
    .msr_pend(msr_pend), .xoff_pend(xoff_pend), .rts_pend(rts_pend), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= (reg_sel == SEL_ENABLE) ? {{(REG_W-EN_W){1'b0}}, en_w} : status_w;
  end
endmodule

// File: rtl/uart_lsr_irq_chk.sv
module uart_lsr_irq_chk
  import uart_lsr_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             reg_sel,
  input logic             wr_en,
  input logic             rd_en,
  input logic             efr_en,
  input logic             ovr_evt,
  input logic             rx_err_present,
  input logic             rts_pin,
  input logic [REG_W-1:0] status,
  input logic [EN_W-1:0]  en,
  input logic [REG_W-1:0] rdata,
  input logic             irq
);
  assert_ovr_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> status[ST_OVR]);

  assert_anyerr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err_present |=> status[ST_ANYERR]);

  assert_locked_ext_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !efr_en |=> en[EN_RTS:EN_SLEEP] == $past(en[EN_RTS:EN_SLEEP]));

  assert_polled_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (en[EN_MDM:EN_RXD] == '0 && !en[EN_XOFF] && !en[EN_RTS]) |-> !irq);

  assert_rts_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rts_pin) && en[EN_RTS] && !(wr_en && reg_sel)) |=> irq);

  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

bind uart_lsr_irq uart_lsr_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en), .rd_en(rd_en),
  .efr_en(efr_en), .ovr_evt(ovr_evt), .rx_err_present(rx_err_present),
  .rts_pin(rts_pin), .status(status_w), .en(en_w), .rdata(rdata), .irq(irq)
);

// File: tb/uart_lsr_irq_tb.sv
module uart_lsr_irq_tb;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       reg_sel = 0, wr_en = 0, rd_en = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic       fifo_en = 0, efr_en = 0;
  logic       rx_nonempty = 0, rx_trig_hit = 0;
  logic [2:0] head_err = 0;
  logic       rx_err_present = 0;
  logic       tx_fifo_empty = 1, tsr_empty = 1;
  logic       ovr_evt = 0, msr_pend = 0, xoff_evt = 0, rts_pin = 0;
  logic       irq;
  int         n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  uart_lsr_irq u_dut (.*);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic s, output logic [7:0] d);
    @(negedge clk); reg_sel = s; rd_en = 1;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic wr(input logic s, input logic [7:0] v);
    @(negedge clk); reg_sel = s; wr_en = 1; wdata = v;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic pulse_ovr();
    @(negedge clk); ovr_evt = 1; @(negedge clk); ovr_evt = 0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(0, d); chk("R4 reset status", d, 8'h60);
    rd(1, d); chk("R8 reset enable", d, 8'h00);
    chk("R10 reset irq", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_rx_status();
    logic [7:0] d;
    @(negedge clk); rx_nonempty = 1; head_err = 3'b101;
    rd(0, d); chk("R1 R3 head errors", d, 8'h75);
    @(negedge clk); head_err = 3'b010;
    rd(0, d); chk("R3 framing only", d, 8'h69);
    @(negedge clk); rx_nonempty = 0;
    rd(0, d); chk("R3 empty masks errors", d, 8'h60);
    head_err = 0;
  endtask

  task automatic t_overrun();
    logic [7:0] d;
    pulse_ovr();
    rd(0, d); chk("R2 overrun set", d, 8'h62);
    rd(0, d); chk("R2 overrun cleared", d, 8'h60);
    @(negedge clk); ovr_evt = 1; reg_sel = 0; rd_en = 1;
    @(negedge clk); ovr_evt = 0; rd_en = 0;
    rd(0, d); chk("R2 set beats clear", d, 8'h62);
    rd(0, d);
  endtask

  task automatic t_anyerr();
    logic [7:0] d;
    @(negedge clk); rx_err_present = 1; @(negedge clk); rx_err_present = 0;
    rd(0, d); chk("R5 anyerr set", d, 8'hE0);
    rd(0, d); chk("R5 anyerr cleared", d, 8'h60);
    @(negedge clk); rx_err_present = 1;
    rd(0, d); rd(0, d); chk("R5 anyerr held", d, 8'hE0);
    @(negedge clk); rx_err_present = 0;
    rd(0, d); rd(0, d); chk("R5 anyerr released", d, 8'h60);
  endtask

  task automatic t_tx();
    logic [7:0] d;
    @(negedge clk); tsr_empty = 0;
    rd(0, d); chk("R4 fifo empty, shifting", d, 8'h20);
    @(negedge clk); tx_fifo_empty = 0;
    rd(0, d); chk("R4 both busy", d, 8'h00);
    @(negedge clk); tx_fifo_empty = 1; tsr_empty = 1;
  endtask

  task automatic t_enable();
    logic [7:0] d;
    efr_en = 0; wr(1, 8'hFF);
    rd(1, d); chk("R8 ext locked", d, 8'h0F);
    efr_en = 1; wr(1, 8'hFF);
    rd(1, d); chk("R8 ext unlocked", d, 8'h7F);
    efr_en = 0; wr(1, 8'h00);
    rd(1, d); chk("R8 ext kept", d, 8'h70);
    wr(0, 8'hFF);
    rd(0, d); chk("R11 status write ignored", d, 8'h60);
    efr_en = 1; wr(1, 8'h00); efr_en = 0;
    rd(1, d); chk("R8 cleared", d, 8'h00);
  endtask

  task automatic t_rx_irq();
    wr(1, 8'h01);
    @(negedge clk); fifo_en = 0; rx_nonempty = 1; #1;
    chk("R6 holding reg irq", {7'b0, irq}, 8'h01);
    @(negedge clk); fifo_en = 1; #1;
    chk("R6 below trigger", {7'b0, irq}, 8'h00);
    @(negedge clk); rx_trig_hit = 1; #1;
    chk("R6 trigger irq", {7'b0, irq}, 8'h01);
    @(negedge clk); rx_trig_hit = 0; rx_nonempty = 0;
  endtask

  task automatic t_other_irq();
    logic [7:0] d;
    wr(1, 8'h02); #1;
    chk("R7 tx ready irq", {7'b0, irq}, 8'h01);
    @(negedge clk); tx_fifo_empty = 0; #1;
    chk("R7 tx busy no irq", {7'b0, irq}, 8'h00);
    wr(1, 8'h04);
    @(negedge clk); rx_nonempty = 1; head_err = 3'b100; #1;
    chk("R7 line irq break", {7'b0, irq}, 8'h01);
    @(negedge clk); rx_nonempty = 0; head_err = 0;
    pulse_ovr(); #1;
    chk("R7 line irq overrun", {7'b0, irq}, 8'h01);
    rd(0, d); #1;
    chk("R7 line irq cleared", {7'b0, irq}, 8'h00);
    wr(1, 8'h08);
    @(negedge clk); msr_pend = 1; #1;
    chk("R7 modem irq", {7'b0, irq}, 8'h01);
    @(negedge clk); msr_pend = 0; tx_fifo_empty = 1;
  endtask

  task automatic t_events();
    logic [7:0] d;
    efr_en = 1; wr(1, 8'h40);
    @(negedge clk); rts_pin = 1;
    @(negedge clk); chk("R9 rts rise irq", {7'b0, irq}, 8'h01);
    rd(0, d); chk("R9 rts cleared, pin high", {7'b0, irq}, 8'h00);
    @(negedge clk); rts_pin = 0;
    @(negedge clk); chk("R9 rts fall no irq", {7'b0, irq}, 8'h00);
    wr(1, 8'h20);
    @(negedge clk); xoff_evt = 1; @(negedge clk); xoff_evt = 0;
    chk("R9 xoff irq", {7'b0, irq}, 8'h01);
    rd(0, d); chk("R9 xoff cleared", {7'b0, irq}, 8'h00);
    wr(1, 8'h00); efr_en = 0;
  endtask

  task automatic t_polled();
    logic [7:0] d;
    @(negedge clk); rx_nonempty = 1; rx_trig_hit = 1; head_err = 3'b111;
    msr_pend = 1; xoff_evt = 1; rts_pin = 1; ovr_evt = 1;
    @(negedge clk); xoff_evt = 0; ovr_evt = 0; #1;
    chk("R10 polled no irq", {7'b0, irq}, 8'h00);
    rd(0, d); chk("R10 polled status", d, 8'h7F);
    @(negedge clk); rx_nonempty = 0; rx_trig_hit = 0; head_err = 0;
    msr_pend = 0; rts_pin = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_rx_status();
    t_overrun();
    t_anyerr();
    t_tx();
    t_enable();
    t_rx_irq();
    t_other_irq();
    t_events();
    t_polled();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule